// File: doc/BRIEF.md
# Dual-Policy Direct-Mapped Data Cache

This block is a direct-mapped data cache placed between a processor request port and a slower word-wide memory port. It holds 64 lines of four 32-bit words. A read or write that hits finishes in the cycle it is presented. A miss holds the requester off while the line is fetched from memory one word per beat, and the access then completes as a hit.

The single `wb_mode` input chooses how writes are handled. With `wb_mode` low the cache is write-through: each write is posted to a four-entry write queue, and a write miss bypasses the cache without allocating a line. With `wb_mode` high the cache is write-back: writes stay in the line and mark it dirty, a write miss allocates the line, and a dirty line is copied to memory only when it is replaced. The victim words are parked in the write queue so that the refill reads go to memory first. The mode may change between any two requests. Dirty lines are written back on replacement in either mode, so no data is lost when the mode changes.

Top module: `wp_dcache`

## Requirements
- R1: The byte address splits into tag = bits 31:10, line index = bits 9:4 and word select = bits 3:2, and bits 1:0 are zero. The index is the block address modulo 64, so byte addresses 1200 and 2224 both land in line 11 and displace each other.
- R2: Reset clears every valid and dirty bit. The first access to any address after reset misses, and while no request is present `cpu_ready` and `mem_req` are low.
- R3: A read hit raises `cpu_ready` with the correct `cpu_rdata` in the same cycle as `cpu_valid` and causes no memory beat.
- R4: On a miss the requester stalls while the four words of the line are read at ascending word addresses starting at the line base. The line becomes valid only after the last beat, and the access then completes with the correct data.
- R5: In write-through mode a write hit updates the line and posts the word to the write queue. `cpu_ready` rises in the same cycle unless all four queue entries are occupied, in which case the write stalls until an entry drains.
- R6: In write-through mode a write miss is posted to memory without any refill read and without allocating the line, so a later read of that address misses.
- R7: In write-back mode a write hit updates only the line, marks it dirty, and produces no memory write.
- R8: In write-back mode a write miss first refills the line and then completes the write into it.
- R9: When a dirty line is replaced, its four words are written to memory. The refill reads for the new line reach memory before those victim writes.
- R10: Before a refill read is issued, every queued write whose address falls in the missing line has been written to memory, so a refill never returns stale data.
- R11: With `wb_mode` fixed at either value or changed between requests, every read returns the value most recently written to that address.
- R12: The memory request is held with a stable address and direction until `mem_ack`. No queue entry is pushed when the queue is full or popped when it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1 = write-back, 0 = write-through; may change between requests |
| cpu_valid | input | 1 | Request present; held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write-beat data |
| mem_ack | input | 1 | Beat accepted; read data valid in this cycle |
| mem_rdata | input | 32 | Read-beat data |

## Verification
Draining the write queue and refilling a line both need the single memory port. The hazard arises when a read miss arrives while queued writes are still waiting. The bench provokes this by holding `mem_ack` low while it posts writes, issuing a read miss to the same line, and then releasing memory. It judges the result by the recorded order of memory beats (the queued write first, then the refill reads) and by the returned data. The opposite ordering is checked in the same way in write-back mode: a dirty victim sits in the queue, and its writes must appear only after the refill reads.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_PREP  = 2'd2,
    ST_FILL  = 2'd3
  } wpc_state_e;

endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
  parameter int LINES = 64,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             inval_en,
  input  logic             dirty_set
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q, dirty_q;

  assign rd_tag   = tag_q[idx];
  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (inval_en) valid_q[idx] <= 1'b0;
      if (fill_en) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end
      if (dirty_set) dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

  AST_FILL_OR_DIRTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && dirty_set)); // R4
endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store #(
  parameter int LINES      = 64,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] word_q [LINES*LINE_WORDS];

  assign rd_data = word_q[{rd_idx, rd_word}];

  always_ff @(posedge clk) begin
    if (we) word_q[{wr_idx, wr_word}] <= wr_data;
  end
endmodule

// File: rtl/wpc_wbuf.sv
module wpc_wbuf #(
  parameter int DEPTH  = 4,
  parameter int AW     = 30,
  parameter int DW     = 32,
  parameter int LINE_W = 28,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [AW-1:0]     push_waddr,
  input  logic [DW-1:0]     push_data,
  input  logic              pop,
  output logic [AW-1:0]     head_waddr,
  output logic [DW-1:0]     head_data,
  output logic              full,
  output logic              empty,
  input  logic [LINE_W-1:0] probe_line,
  output logic              probe_hit
);
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] line_match;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;

  assign full       = &vld_q;
  assign empty      = ~|vld_q;
  assign head_waddr = addr_q[rd_ptr_q];
  assign head_data  = data_q[rd_ptr_q];

  for (genvar e = 0; e < DEPTH; e++) begin : g_probe
    assign line_match[e] = vld_q[e] && (addr_q[e][AW-1 -: LINE_W] == probe_line);
  end
  assign probe_hit = |line_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (pop) begin
        vld_q[rd_ptr_q] <= 1'b0;
        rd_ptr_q        <= rd_ptr_q + 1'b1;
      end
      if (push) begin
        vld_q[wr_ptr_q] <= 1'b1;
        wr_ptr_q        <= wr_ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr_q] <= push_waddr;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R12
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R12
endmodule

// File: rtl/wp_dcache.sv
module wp_dcache
  import wpc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 64,
  parameter int LINE_WORDS = 4,
  parameter int WBUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_mode,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = WSEL_W + 2;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = ADDR_W - OFF_W;

  // Word address of one beat within a line.
  function automatic logic [ADDR_W-3:0] beat_waddr(input logic [LINE_W-1:0] line,
                                                   input logic [WSEL_W-1:0] w);
    return {line, w};
  endfunction

  logic [IDX_W-1:0]  cpu_idx;
  logic [TAG_W-1:0]  cpu_tag;
  logic [WSEL_W-1:0] cpu_wsel;
  logic [LINE_W-1:0] cpu_line;
  assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign cpu_idx  = cpu_addr[OFF_W +: IDX_W];
  assign cpu_wsel = cpu_addr[2 +: WSEL_W];
  assign cpu_line = cpu_addr[ADDR_W-1:OFF_W];

  wpc_state_e        state_q, state_d;
  logic [WSEL_W-1:0] beat_q, beat_d;
  logic              wb_hold_q;

  logic [TAG_W-1:0]  t_tag;
  logic              t_valid, t_dirty;
  logic              fill_en, inval_en, dirty_set;

  logic [DATA_W-1:0] ds_rdata, ds_wdata;
  logic [WSEL_W-1:0] ds_rword, ds_wword;
  logic              ds_we;

  logic              wb_push, wb_pop, wb_full, wb_empty, buf_match;
  logic [ADDR_W-3:0] wb_push_waddr, wb_head_waddr;
  logic [DATA_W-1:0] wb_push_data, wb_head_data;

  // Named internal events.
  logic hit, in_idle, in_evict, in_prep, fill_on, last_beat;
  logic ev_rd_hit, ev_wr_hit_wb, ev_wr_wt, ev_miss;
  logic evict_push, prep_go, buf_offer, fill_beat;

  assign hit          = t_valid && (t_tag == cpu_tag);
  assign in_idle      = (state_q == ST_IDLE);
  assign in_evict     = (state_q == ST_EVICT);
  assign in_prep      = (state_q == ST_PREP);
  assign fill_on      = (state_q == ST_FILL);
  assign last_beat    = (beat_q == WSEL_W'(LINE_WORDS - 1));
  assign ev_rd_hit    = in_idle && cpu_valid && !cpu_we && hit;
  assign ev_wr_hit_wb = in_idle && cpu_valid && cpu_we && wb_mode && hit;
  assign ev_wr_wt     = in_idle && cpu_valid && cpu_we && !wb_mode && !wb_full;
  assign ev_miss      = in_idle && cpu_valid && !hit && (!cpu_we || wb_mode);
  assign evict_push   = in_evict && !wb_full;
  assign prep_go      = in_prep && !buf_match && !wb_hold_q;
  assign fill_beat    = fill_on && mem_ack;
  // Queue drains when memory is free; refill reads go before parked victims.
  assign buf_offer    = !wb_empty && (wb_hold_q || in_idle || (in_prep && buf_match)
                                      || (in_evict && wb_full));

  always_comb begin
    state_d  = state_q;
    beat_d   = beat_q;
    fill_en  = 1'b0;
    inval_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (ev_miss) begin
        state_d = (t_valid && t_dirty) ? ST_EVICT : ST_PREP;
        beat_d  = '0;
      end
      ST_EVICT: if (!wb_full) begin
        beat_d = beat_q + 1'b1;
        if (last_beat) state_d = ST_PREP;
      end
      ST_PREP: if (prep_go) begin
        state_d  = ST_FILL;
        inval_en = 1'b1;
        beat_d   = '0;
      end
      ST_FILL: if (mem_ack) begin
        beat_d = beat_q + 1'b1;
        if (last_beat) begin
          state_d = ST_IDLE;
          fill_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      beat_q    <= '0;
      wb_hold_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      beat_q    <= beat_d;
      wb_hold_q <= buf_offer && !mem_ack;
    end
  end

  assign dirty_set = ev_wr_hit_wb;

  wpc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(cpu_idx),
    .rd_tag(t_tag), .rd_valid(t_valid), .rd_dirty(t_dirty),
    .fill_en(fill_en), .fill_tag(cpu_tag), .inval_en(inval_en), .dirty_set(dirty_set)
  );

  assign ds_we    = fill_beat || ev_wr_hit_wb || (ev_wr_wt && hit);
  assign ds_wword = fill_on ? beat_q : cpu_wsel;
  assign ds_wdata = fill_on ? mem_rdata : cpu_wdata;
  assign ds_rword = in_evict ? beat_q : cpu_wsel;

  wpc_data_store #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rd_idx(cpu_idx), .rd_word(ds_rword), .rd_data(ds_rdata),
    .we(ds_we), .wr_idx(cpu_idx), .wr_word(ds_wword), .wr_data(ds_wdata)
  );

  assign wb_push       = evict_push || ev_wr_wt;
  assign wb_push_waddr = in_evict ? beat_waddr({t_tag, cpu_idx}, beat_q) : cpu_addr[ADDR_W-1:2];
  assign wb_push_data  = in_evict ? ds_rdata : cpu_wdata;
  assign wb_pop        = buf_offer && mem_ack;

  wpc_wbuf #(.DEPTH(WBUF_DEPTH), .AW(ADDR_W-2), .DW(DATA_W), .LINE_W(LINE_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .push(wb_push), .push_waddr(wb_push_waddr), .push_data(wb_push_data),
    .pop(wb_pop), .head_waddr(wb_head_waddr), .head_data(wb_head_data),
    .full(wb_full), .empty(wb_empty), .probe_line(cpu_line), .probe_hit(buf_match)
  );

  assign mem_req   = fill_on || buf_offer;
  assign mem_we    = !fill_on;
  assign mem_addr  = fill_on ? {beat_waddr(cpu_line, beat_q), 2'b00} : {wb_head_waddr, 2'b00};
  assign mem_wdata = wb_head_data;

  assign cpu_ready = ev_rd_hit || ev_wr_hit_wb || ev_wr_wt;
  assign cpu_rdata = ds_rdata;

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> (cpu_addr[1:0] == 2'b00)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12
  AST_FILL_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_beat && !last_beat) |=> (fill_on && mem_addr == $past(mem_addr) + ADDR_W'(4))); // R4
  AST_FILL_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fill_on |-> !t_valid); // R4
  AST_FILL_NO_STALE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_on |-> !buf_match); // R10
endmodule

// File: tb/wp_dcache_tb.sv
`timescale 1ns/1ps
module wp_dcache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_mode = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int fails = 0;
  int proto_err = 0;
  int lat = 1;
  logic mem_hold = 1'b0;
  int wait_c = 0;
  logic [31:0] mem [1024];
  logic [31:0] ref_m [1024];
  logic        log_we [256];
  logic [31:0] log_addr [256];
  int log_n = 0;
  logic prev_pend = 1'b0;
  logic prev_we = 1'b0;
  logic [31:0] prev_addr = '0;

  always #2 clk = ~clk;

  wp_dcache dut_i (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] init_word(input int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  // Memory model: ack after lat waiting cycles unless held.
  assign mem_ack   = mem_req && (wait_c >= lat) && !mem_hold;
  assign mem_rdata = mem[mem_addr[11:2]];

  initial for (int i = 0; i < 1024; i++) mem[i] = init_word(i);

  always @(posedge clk) begin
    if (mem_req && !mem_ack) wait_c <= wait_c + 1; else wait_c <= 0;
    if (rst_n && prev_pend && (!mem_req || mem_addr != prev_addr || mem_we != prev_we))
      proto_err <= proto_err + 1;
    prev_pend <= rst_n && mem_req && !mem_ack;
    prev_addr <= mem_addr;
    prev_we   <= mem_we;
    if (mem_req && mem_ack) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      log_we[log_n[7:0]]   <= mem_we;
      log_addr[log_n[7:0]] <= mem_addr;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    idle(40);
    @(negedge clk); rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    for (int i = 0; i < 1024; i++) ref_m[i] = mem[i];
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; waits = 0;
    #1;
    while (!cpu_ready) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_valid = 1'b0;
    if (we) ref_m[a[11:2]] = d;
  endtask

  task automatic chk_beat(input int k, input logic we, input logic [31:0] a, input string req);
    chk(k < log_n && log_we[k[7:0]] == we && log_addr[k[7:0]] == a, req,
        {log_we[k[7:0]], log_addr[k[7:0]][30:0]}, {we, a[30:0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd150000, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int w, mark, nw, nr;
    // ---------- write-through, reset and refill ----------
    wb_mode = 1'b0;
    do_reset();
    idle(1); #1;
    chk(!cpu_ready && !mem_req, "R2 idle outputs after reset", {cpu_ready, mem_req}, 0);
    mark = log_n;
    access(0, 32'd1200, 0, rd, w);
    chk(w > 0, "R2 first access misses", w, 1);
    chk(rd == init_word(300), "R4 refill data", rd, init_word(300));
    for (int k = 0; k < 4; k++) chk_beat(mark + k, 1'b0, 32'd1200 + 32'(4 * k), "R4 ascending refill");
    chk(((1200 >> 4) % 64) == 11 && ((2224 >> 4) % 64) == 11, "R1 index arithmetic", 11, 11);
    access(0, 32'd2224, 0, rd, w);
    chk(w > 0 && rd == init_word(556), "R1 conflicting line", rd, init_word(556));
    access(0, 32'd1204, 0, rd, w);
    chk(w > 0, "R1 line 11 displaced", w, 1);
    idle(5); mark = log_n;
    access(0, 32'd1208, 0, rd, w);
    idle(5);
    chk(w == 0 && rd == init_word(302) && log_n == mark, "R3 read hit", rd, init_word(302));

    // ---------- write-through writes ----------
    mark = log_n;
    access(1, 32'h40, 32'hA0A0_0001, rd, w);
    chk(w == 0, "R5 posted write completes at once", w, 0);
    idle(20);
    nw = 0; nr = 0;
    for (int k = mark; k < log_n; k++) if (log_we[k[7:0]]) nw++; else nr++;
    chk(nw == 1 && nr == 0, "R6 write around, no refill", {nw[15:0], nr[15:0]}, 32'h0001_0000);
    chk(mem[16] == 32'hA0A0_0001, "R6 memory updated", mem[16], 32'hA0A0_0001);
    access(0, 32'h40, 0, rd, w);
    chk(w > 0 && rd == 32'hA0A0_0001, "R6 not allocated", rd, 32'hA0A0_0001);
    access(1, 32'h44, 32'hB0B0_0002, rd, w);
    idle(20);
    chk(w == 0 && mem[17] == 32'hB0B0_0002, "R5 write hit reaches memory", mem[17], 32'hB0B0_0002);
    access(0, 32'h44, 0, rd, w);
    chk(w == 0 && rd == 32'hB0B0_0002, "R5 write hit updates line", rd, 32'hB0B0_0002);
    mem_hold = 1'b1;
    for (int k = 0; k < 4; k++) begin
      access(1, 32'h48 + 32'(4 * k), 32'hC000_0000 + 32'(k), rd, w);
      chk(w == 0, "R5 queue accepts four", w, 0);
    end
    fork begin idle(10); mem_hold = 1'b0; end join_none
    access(1, 32'h58, 32'hC000_0004, rd, w);
    chk(w >= 8, "R5 stall when queue full", w, 8);
    idle(30);

    // ---------- drain-before-refill collision ----------
    mem_hold = 1'b1;
    mark = log_n;
    access(1, 32'hC0, 32'hD0D0_0003, rd, w);
    fork begin idle(5); mem_hold = 1'b0; end join_none
    access(0, 32'hC0, 0, rd, w);
    chk(rd == 32'hD0D0_0003, "R10 refill sees queued write", rd, 32'hD0D0_0003);
    chk_beat(mark, 1'b1, 32'hC0, "R10 queued write first");
    chk_beat(mark + 1, 1'b0, 32'hC0, "R10 refill after drain");

    // ---------- write-back ----------
    wb_mode = 1'b1;
    do_reset();
    mark = log_n;
    access(1, 32'h0, 32'hE0E0_0005, rd, w);
    idle(20);
    nw = 0; nr = 0;
    for (int k = mark; k < log_n; k++) if (log_we[k[7:0]]) nw++; else nr++;
    chk(w > 0 && nr == 4, "R8 write miss allocates", nr, 4);
    access(1, 32'h4, 32'hE0E0_0006, rd, w);
    idle(20);
    nw = 0;
    for (int k = mark; k < log_n; k++) if (log_we[k[7:0]]) nw++;
    chk(w == 0 && nw == 0 && mem[0] == init_word(0), "R7 write hit stays in cache", nw, 0);
    access(0, 32'h0, 0, rd, w);
    chk(w == 0 && rd == 32'hE0E0_0005, "R8 write completed into line", rd, 32'hE0E0_0005);
    mark = log_n;
    access(0, 32'h400, 0, rd, w);
    idle(30);
    chk(rd == init_word(256), "R9 new line data", rd, init_word(256));
    for (int k = 0; k < 4; k++) chk_beat(mark + k, 1'b0, 32'h400 + 32'(4 * k), "R9 refill first");
    for (int k = 0; k < 4; k++) chk_beat(mark + 4 + k, 1'b1, 32'(4 * k), "R9 victim written");
    chk(mem[0] == 32'hE0E0_0005 && mem[1] == 32'hE0E0_0006, "R9 victim data", mem[1], 32'hE0E0_0006);

    // ---------- random traffic: WT, WB, mixed ----------
    for (int ph = 0; ph < 3; ph++) begin
      wb_mode = (ph == 1);
      do_reset();
      for (int n = 0; n < 2500; n++) begin
        logic [31:0] a;
        logic we;
        a = {20'd0, 2'($urandom), 4'd0, 2'($urandom), 2'($urandom), 2'b00};
        we = ($urandom % 3) == 0;
        lat = $urandom % 4;
        if (ph == 2) wb_mode = $urandom % 2;
        access(we, a, $urandom, rd, w);
        if (!we) chk(rd == ref_m[a[11:2]], "R11 random read", rd, ref_m[a[11:2]]);
      end
    end
    idle(40);
    chk(proto_err == 0, "R12 request held until ack", proto_err, 0);
    finish_run();
  end
endmodule